// File: doc/BRIEF.md
# Programmable LED Blink Timer with Auto-Stop

This block drives a single LED with a repeating on/off waveform. A free-running prescaler produces a time-base tick every 2^n clocks, where n comes from a 4-bit select field. Each tick advances a 12-bit phase counter that restarts when it reaches the programmed period. The LED is lit while the phase is below the programmed duty value, so software sets both the blink rate and the on time with two register writes.

An optional auto-stop mode limits the number of blinks. A 16-bit remaining-period count is decremented at every period boundary. When it runs out, the block switches itself off and raises a sticky event flag. The flag drives the interrupt output unless the mask bit in the control register hides it. Software clears the flag by reloading the count.

All configuration goes through a small word-indexed register port with single-cycle writes and combinational reads.

Top module: `led_blink_timer`

## Requirements
- R1: After a synchronous reset every register reads zero, `led_out` is 0 and `irq_out` is 0.
- R2: `bus_addr` selects a register by word index: 0 is control, 1 is period, 2 is duty and 3 is the auto-stop count. In the control register, bits [3:0] are the time-base select, bit 4 is run, bit 5 is auto-stop enable and bit 6 is interrupt mask. Period and duty are 12 bits wide, the count is 16 bits wide, and unused upper bits read as zero.
- R3: A time-base select written above 13 is stored and read back as 13.
- R4: While running with select n, the phase counter advances once every 2^n clocks. The first advance comes 2^n clocks after run is set.
- R5: The phase counter steps through 0 to P-1, where P is the period value; a period of 0 behaves as 1. The LED is on while the phase is below the duty value.
- R6: A duty of 0 keeps the LED dark for the whole period. A duty equal to or above the period keeps the LED lit continuously.
- R7: Clearing run turns the LED off at once. It also restarts the prescaler and the phase counter, so the next run begins from phase 0.
- R8: With auto-stop enabled, each period end decrements the count. At the period end that consumes the last remaining period, or at the first period end when the count was loaded with 0, the block clears run, sets the count to 0 and sets the event flag.
- R9: `irq_out` equals the event flag while mask is 0 and is 0 while mask is 1. Writes to the control register leave the flag unchanged. Only a write to the count register clears the flag.
- R10: With auto-stop disabled, the count holds its value and the LED keeps blinking.
- R11: In a cycle with a register write, the auto-stop step is skipped: the count, run bit and flag change only as the write dictates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_addr | input | 2 | Register word index |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the selected register |
| led_out | output | 1 | LED drive, 1 is lit |
| irq_out | output | 1 | Auto-stop event interrupt |

## Verification
The hardest case to reach is a register write that lands exactly on a period end while auto-stop is counting. If that write were not given priority, the count would silently lose a decrement. The stimulus sets the period to 1 with the shortest time base, so every clock ends a period. It then issues back-to-back writes and checks that the count is frozen over those cycles and resumes decrementing once they stop. Random sessions with short periods and small counts make the stop events and their interaction with writes frequent, and a cycle-level reference model checks the outputs in every cycle.

// File: rtl/led_blink_pkg.sv
package led_blink_pkg;

    // Largest legal time-base select and the prescaler width it implies
    localparam int unsigned TBS_MAX = 13;
    localparam int unsigned TBS_W   = 4;
    localparam int unsigned DIV_W   = TBS_MAX;

    // Default datapath widths
    localparam int unsigned DEF_PER_W  = 12;
    localparam int unsigned DEF_STOP_W = 16;
    localparam int unsigned DEF_DATA_W = 16;
    localparam int unsigned CTRL_W     = TBS_W + 3;

    // Control register layout: tbs in [3:0], run [4], auto_stop [5], irq_mask [6]
    typedef struct packed {
        logic             irq_mask;
        logic             auto_stop;
        logic             run;
        logic [TBS_W-1:0] tbs;
    } ctrl_t;

    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_PERIOD = 2'd1,
        SEL_DUTY   = 2'd2,
        SEL_STOP   = 2'd3
    } reg_sel_e;

    function automatic logic [TBS_W-1:0] clamp_tbs(input logic [TBS_W-1:0] raw);
        return (raw > TBS_W'(TBS_MAX)) ? TBS_W'(TBS_MAX) : raw;
    endfunction

    function automatic logic [DIV_W-1:0] tick_mask(input logic [TBS_W-1:0] sel);
        return ~({DIV_W{1'b1}} << sel);
    endfunction

endpackage

// File: rtl/led_blink_prescale.sv
module led_blink_prescale
    import led_blink_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [TBS_W-1:0] tbs,
    output logic             tick
);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] sel_mask;

    assign sel_mask = tick_mask(tbs);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + DIV_W'(1);
        end
    end

    assign tick = run && ((div_q & sel_mask) == sel_mask);

    // A divided time base never ticks in two consecutive cycles
    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
        (tick && tbs != '0) |=> (!tick || tbs != $past(tbs)))
        else $error("tick spacing violated"); // R4

endmodule

// File: rtl/led_blink_wave.sv
module led_blink_wave #(
    parameter int unsigned PER_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic [PER_W-1:0] period,
    input  logic [PER_W-1:0] duty,
    output logic             wrap,
    output logic             led
);

    localparam int unsigned EXT_W = PER_W + 1;

    logic [PER_W-1:0] phase_q;
    logic [EXT_W-1:0] phase_next;

    assign phase_next = {1'b0, phase_q} + EXT_W'(1);
    assign wrap       = tick && (phase_next >= {1'b0, period});

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            phase_q <= '0;
        end else if (tick) begin
            phase_q <= wrap ? '0 : phase_next[PER_W-1:0];
        end
    end

    assign led = run && (phase_q < duty);

    // Each tick either restarts the phase or moves it up by exactly one
    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
        (run && tick) |=> (phase_q == '0 || phase_q == $past(phase_q) + PER_W'(1)))
        else $error("phase step broken"); // R5

    // Without a tick the phase holds
    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (run && !tick) |=> (phase_q == $past(phase_q) || !run))
        else $error("phase moved without tick"); // R4

endmodule

// File: rtl/led_blink_regs.sv
module led_blink_regs
    import led_blink_pkg::*;
#(
    parameter int unsigned PER_W  = 12,
    parameter int unsigned STOP_W = 16,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              wrap,
    output ctrl_t             ctrl,
    output logic [PER_W-1:0]  period,
    output logic [PER_W-1:0]  duty,
    output logic              event_flag
);

    reg_sel_e          sel;
    ctrl_t             ctrl_q;
    logic [PER_W-1:0]  period_q;
    logic [PER_W-1:0]  duty_q;
    logic [STOP_W-1:0] left_q;
    logic              flag_q;
    logic              stop_step;
    logic              last_period;
    logic              unused_wdata_hi;

    assign sel         = reg_sel_e'(bus_addr);
    assign stop_step   = wrap && ctrl_q.run && ctrl_q.auto_stop && !bus_wr;
    assign last_period = (left_q <= STOP_W'(1));
    assign unused_wdata_hi = ^bus_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            period_q <= '0;
            duty_q   <= '0;
            left_q   <= '0;
            flag_q   <= 1'b0;
        end else if (bus_wr) begin
            unique case (sel)
                SEL_CTRL: begin
                    ctrl_q.irq_mask  <= bus_wdata[6];
                    ctrl_q.auto_stop <= bus_wdata[5];
                    ctrl_q.run       <= bus_wdata[4];
                    ctrl_q.tbs       <= clamp_tbs(bus_wdata[TBS_W-1:0]);
                end
                SEL_PERIOD: period_q <= bus_wdata[PER_W-1:0];
                SEL_DUTY:   duty_q   <= bus_wdata[PER_W-1:0];
                SEL_STOP: begin
                    left_q <= bus_wdata[STOP_W-1:0];
                    flag_q <= 1'b0;
                end
                default: ;
            endcase
        end else if (stop_step) begin
            if (last_period) begin
                ctrl_q.run <= 1'b0;
                left_q     <= '0;
                flag_q     <= 1'b1;
            end else begin
                left_q <= left_q - STOP_W'(1);
            end
        end
    end

    always_comb begin
        unique case (sel)
            SEL_CTRL:   bus_rdata = DATA_W'(ctrl_q);
            SEL_PERIOD: bus_rdata = DATA_W'(period_q);
            SEL_DUTY:   bus_rdata = DATA_W'(duty_q);
            SEL_STOP:   bus_rdata = DATA_W'(left_q);
            default:    bus_rdata = '0;
        endcase
    end

    assign ctrl       = ctrl_q;
    assign period     = period_q;
    assign duty       = duty_q;
    assign event_flag = flag_q;

    AST_TBS_LEGAL: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.tbs <= TBS_W'(TBS_MAX))
        else $error("tbs above limit"); // R3

    AST_STOP_FINAL: assert property (@(posedge clk) disable iff (rst)
        (stop_step && last_period) |=> (!ctrl_q.run && flag_q && left_q == '0))
        else $error("auto-stop did not halt"); // R8

    AST_STOP_DEC: assert property (@(posedge clk) disable iff (rst)
        (stop_step && !last_period) |=> (left_q == $past(left_q) - STOP_W'(1)))
        else $error("auto-stop count not decremented"); // R8

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !(bus_wr && sel == SEL_STOP)) |=> flag_q)
        else $error("event flag dropped"); // R9

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && sel != SEL_STOP) |=> (left_q == $past(left_q)))
        else $error("count moved during write"); // R11

endmodule

// File: rtl/led_blink_timer.sv
module led_blink_timer
    import led_blink_pkg::*;
#(
    parameter int unsigned PER_W  = DEF_PER_W,
    parameter int unsigned STOP_W = DEF_STOP_W,
    parameter int unsigned DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              led_out,
    output logic              irq_out
);

    ctrl_t            ctrl;
    logic [PER_W-1:0] period;
    logic [PER_W-1:0] duty;
    logic             event_flag;
    logic             tick;
    logic             wrap;
    logic             led;

    led_blink_regs #(
        .PER_W (PER_W),
        .STOP_W(STOP_W),
        .DATA_W(DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .wrap      (wrap),
        .ctrl      (ctrl),
        .period    (period),
        .duty      (duty),
        .event_flag(event_flag)
    );

    led_blink_prescale u_prescale (
        .clk (clk),
        .rst (rst),
        .run (ctrl.run),
        .tbs (ctrl.tbs),
        .tick(tick)
    );

    led_blink_wave #(
        .PER_W(PER_W)
    ) u_wave (
        .clk   (clk),
        .rst   (rst),
        .run   (ctrl.run),
        .tick  (tick),
        .period(period),
        .duty  (duty),
        .wrap  (wrap),
        .led   (led)
    );

    assign led_out = led;
    assign irq_out = event_flag && !ctrl.irq_mask;

    AST_DARK_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !ctrl.run |-> !led_out)
        else $error("LED lit while stopped"); // R7

    AST_DUTY_ZERO_DARK: assert property (@(posedge clk) disable iff (rst)
        (duty == '0) |-> !led_out)
        else $error("LED lit with zero duty"); // R6

endmodule

// File: tb/led_blink_timer_tb.sv
module led_blink_timer_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic        led_out;
    logic        irq_out;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    led_blink_timer u_dut (
        .clk      (clk),
        .rst      (rst),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .led_out  (led_out),
        .irq_out  (irq_out)
    );

    // Reference model built from the requirements
    logic [3:0]  m_tbs;
    logic        m_run, m_as, m_mask, m_flag;
    logic [11:0] m_per, m_duty, m_wc;
    logic [15:0] m_left;
    logic [12:0] m_pre, m_msk;
    logic        m_tk, m_wp;

    always @(posedge clk) begin
        if (rst) begin
            m_tbs = 0; m_run = 0; m_as = 0; m_mask = 0; m_flag = 0;
            m_per = 0; m_duty = 0; m_wc = 0; m_left = 0; m_pre = 0;
        end else begin
            m_msk = ~(13'h1fff << m_tbs);
            m_tk  = m_run && ((m_pre & m_msk) == m_msk);
            m_wp  = m_tk && (int'(m_wc) + 1 >= int'(m_per));
            if (!m_run) begin
                m_pre = 0; m_wc = 0;
            end else begin
                m_pre = m_pre + 13'd1;
                if (m_tk) m_wc = m_wp ? 12'd0 : m_wc + 12'd1;
            end
            if (bus_wr) begin
                case (bus_addr)
                    2'd0: begin
                        m_mask = bus_wdata[6]; m_as = bus_wdata[5]; m_run = bus_wdata[4];
                        m_tbs  = (bus_wdata[3:0] > 4'd13) ? 4'd13 : bus_wdata[3:0];
                    end
                    2'd1: m_per  = bus_wdata[11:0];
                    2'd2: m_duty = bus_wdata[11:0];
                    default: begin m_left = bus_wdata; m_flag = 0; end
                endcase
            end else if (m_wp && m_run && m_as) begin
                if (m_left <= 16'd1) begin
                    m_run = 0; m_left = 0; m_flag = 1;
                end else begin
                    m_left = m_left - 16'd1;
                end
            end
        end
    end

    function automatic logic exp_led();
        return m_run && (m_wc < m_duty);
    endfunction

    function automatic logic exp_irq();
        return m_flag && !m_mask;
    endfunction

    function automatic logic [15:0] exp_rd(input logic [1:0] a);
        case (a)
            2'd0:    return {9'd0, m_mask, m_as, m_run, m_tbs};
            2'd1:    return {4'd0, m_per};
            2'd2:    return {4'd0, m_duty};
            default: return m_left;
        endcase
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] a, input logic [15:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic model_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check("R5 model led", {15'd0, led_out}, {15'd0, exp_led()});
            check("R9 model irq", {15'd0, irq_out}, {15'd0, exp_irq()});
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 led", {15'd0, led_out}, 16'd0);
        check("R1 irq", {15'd0, irq_out}, 16'd0);
        for (int a = 0; a < 4; a++) rd_chk("R1 regs", 2'(a), 16'd0);

        // R2 field layout and read-back widths
        wr(2'd1, 16'hFABC); rd_chk("R2 period", 2'd1, 16'h0ABC);
        wr(2'd2, 16'h1234); rd_chk("R2 duty", 2'd2, 16'h0234);
        wr(2'd3, 16'hBEEF); rd_chk("R2 count", 2'd3, 16'hBEEF);
        wr(2'd0, 16'hFF45); rd_chk("R2 ctrl", 2'd0, 16'h0045);

        // R3 clamp of the time-base select
        wr(2'd0, 16'h000F); rd_chk("R3 sel15", 2'd0, 16'h000D);
        wr(2'd0, 16'h000E); rd_chk("R3 sel14", 2'd0, 16'h000D);

        // R5 period 4 duty 2, fastest time base
        wr(2'd1, 16'd4); wr(2'd2, 16'd2); wr(2'd0, 16'h0010);
        for (int i = 0; i < 8; i++) begin
            if (i > 0) @(negedge clk);
            check("R5 pattern", {15'd0, led_out}, {15'd0, (i % 4) < 2});
        end

        // R7 stop darkens at once
        wr(2'd0, 16'h0000);
        check("R7 dark", {15'd0, led_out}, 16'd0);

        // R4 select 2: each phase lasts four clocks
        wr(2'd1, 16'd2); wr(2'd2, 16'd1); wr(2'd0, 16'h0012);
        for (int i = 0; i < 12; i++) begin
            if (i > 0) @(negedge clk);
            check("R4 divided", {15'd0, led_out}, {15'd0, ((i / 4) % 2) == 0});
        end
        wr(2'd0, 16'h0000);

        // R6 duty extremes
        wr(2'd1, 16'd3); wr(2'd2, 16'd0); wr(2'd0, 16'h0010);
        for (int i = 0; i < 9; i++) begin
            check("R6 zero duty", {15'd0, led_out}, 16'd0); @(negedge clk);
        end
        wr(2'd2, 16'd3);
        for (int i = 0; i < 9; i++) begin
            check("R6 duty=period", {15'd0, led_out}, 16'd1); @(negedge clk);
        end
        wr(2'd2, 16'd4000);
        for (int i = 0; i < 9; i++) begin
            check("R6 duty>period", {15'd0, led_out}, 16'd1); @(negedge clk);
        end
        wr(2'd0, 16'h0000);

        // R8 auto-stop after three periods of two ticks, masked
        wr(2'd1, 16'd2); wr(2'd2, 16'd1); wr(2'd3, 16'd3); wr(2'd0, 16'h0070);
        @(negedge clk); @(negedge clk);
        rd_chk("R8 decrement", 2'd3, 16'd2);
        model_cycles(8);
        rd_chk("R8 run cleared", 2'd0, 16'h0060);
        rd_chk("R8 count zero", 2'd3, 16'd0);
        check("R9 masked", {15'd0, irq_out}, 16'd0);
        wr(2'd0, 16'h0000);
        check("R9 unmasked", {15'd0, irq_out}, 16'd1);
        wr(2'd0, 16'h0001);
        check("R9 sticky over ctrl write", {15'd0, irq_out}, 16'd1);
        wr(2'd3, 16'd0);
        check("R9 cleared by reload", {15'd0, irq_out}, 16'd0);

        // R8 count loaded with zero stops at the first period end
        wr(2'd0, 16'h0030);
        model_cycles(3);
        rd_chk("R8 zero load", 2'd0, 16'h0020);
        check("R8 zero load irq", {15'd0, irq_out}, 16'd1);

        // R10 no auto-stop: count holds, blinking continues
        wr(2'd3, 16'd5); wr(2'd0, 16'h0010);
        model_cycles(20);
        rd_chk("R10 count held", 2'd3, 16'd5);
        rd_chk("R10 still running", 2'd0, 16'h0010);
        wr(2'd0, 16'h0000);

        // R11 writes on period-end cycles suppress the step
        wr(2'd1, 16'd1); wr(2'd3, 16'd5); wr(2'd0, 16'h0030);
        wr(2'd2, 16'd1); wr(2'd2, 16'd1); wr(2'd2, 16'd1);
        rd_chk("R11 frozen", 2'd3, 16'd5);
        @(negedge clk); @(negedge clk);
        rd_chk("R11 resumed", 2'd3, 16'd3);
        wr(2'd0, 16'h0000);

        // Random sessions against the model
        for (int s = 0; s < 40; s++) begin
            int nw;
            nw = int'($urandom % 4) + 1;
            for (int k = 0; k < nw; k++) begin
                logic [1:0] a;
                logic [15:0] d;
                a = 2'($urandom % 4);
                case (a)
                    2'd0: d = {9'd0, 3'($urandom % 8),
                               (($urandom % 8) == 0) ? 4'($urandom % 16) : 4'($urandom % 3)};
                    2'd1: d = 16'($urandom % 7);
                    2'd2: d = 16'($urandom % 9);
                    default: d = 16'($urandom % 6);
                endcase
                wr(a, d);
            end
            model_cycles(int'($urandom % 150) + 20);
            for (int a = 0; a < 4; a++) rd_chk("R2 model read", 2'(a), exp_rd(2'(a)));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule